// File: doc/BRIEF.md
# Serial Flash Page Program Engine

This block is the command side of a small serial NOR flash that a host drives over a four-wire SPI link in mode 0. It decodes the instruction byte that follows a chip-select fall and holds a write-enable latch. It captures a 24-bit address and collects page-program data into a 256-byte staging buffer, where writes past the end of the page wrap back to the start of the same page. When chip select rises it decides whether to commit the buffer.

A commit happens only when four conditions hold: the latch was set, at least one whole data byte arrived, chip select rose on a byte boundary, and the target page is outside the region locked by the three protect inputs. A committed page is written into an on-chip byte array during a self-timed busy period. Each written byte can only clear bits. The host polls a status byte to see when the busy period ends, and it can read the array back with a plain read command. All SPI pins are sampled in the system clock domain, and SCK must stay at least four system clocks in each phase.

Top module: `spi_pp_flash`

## Requirements
- R1: SPI runs in mode 0. The block samples SPI_MOSI on SCK rising edges and drives SPI_MISO on falling edges. Every byte travels MSB first. The opcodes are 0x06 write enable, 0x02 page program, 0x05 read status and 0x03 read data, and every other opcode is ignored.
- R2: An 0x06 command received while not busy sets the write-enable latch, which reads back as status bit 1.
- R3: An 0x02 command received while the latch is clear is ignored. Busy stays 0 and the array is unchanged.
- R4: Programming ANDs each stored byte with its data byte, so bits can only go from 1 to 0.
- R5: A program with fewer than 256 data bytes changes only the addressed bytes. The rest of the page keeps its contents.
- R6: Data that runs past page offset 0xFF continues at offset 0x00 of the same page. Address bits at or above the array width (default 10 bits), including bits 23 to 20, are ignored.
- R7: When more than 256 data bytes arrive, each page offset keeps the last byte sent to it.
- R8: No programming happens, and busy stays 0, if chip select rises partway through a byte or before any data byte.
- R9: After a valid chip-select rise, busy and status bit 0 read 1 for exactly TPP_CYCLES system clocks, starting one clock after the rise is sampled. The latch is clear for the whole busy period.
- R10: prot_bits locks pages from the top of the array downward. A value of 0 locks nothing, 7 locks every page, and a value n from 1 to 6 locks the top min(2^(n-1), pages) pages. A program aimed at a locked page does not run. prot_bits reads back as status bits 4:2.
- R11: While busy, every opcode except 0x05 is ignored. 0x06 leaves the latch clear, and 0x03 returns 0x00.
- R12: 0x03 followed by three address bytes returns array bytes from that address on, incrementing and wrapping at the end of the array.
- R13: The status byte is {3'b000, prot_bits, latch, busy}. It repeats for as long as chip select stays low, and each repeat shows the current values.
- R14: After reset the latch and busy are 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, synchronous to clk |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not selected |
| prot_bits | input | 3 | Block-protect level |
| busy | output | 1 | High during the self-timed program period |

## Verification
A byte is captured one clock after its eighth SCK rise. Its reply is loaded one clock later and appears on SPI_MISO at the next SCK fall. The bench therefore samples SPI_MISO right before it raises SCK, four clocks after the fall. Busy rises on the clock edge that first sees chip select high. The bench raises chip select on a falling clock edge and, starting at the next falling edge, counts the falling edges on which busy is high, expecting exactly TPP_CYCLES. Array contents are checked only after busy has dropped, against a bench model that applies wraparound, last-writer-wins and AND.

// File: rtl/spi_pp_pkg.sv
// Shared constants, state type and protection rule for the page program engine.
package spi_pp_pkg;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam int OFS_W      = 8;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [2:0] {
        ST_OPCODE, ST_ADDR, ST_PROG_DATA, ST_STATUS, ST_READ, ST_DISCARD
    } cmd_state_t;

    // True when page index pg sits in the top region locked by level lvl.
    function automatic logic page_locked(input logic [2:0] lvl, input int pg, input int num_pages);
        int span;
        if (lvl == 3'd0) return 1'b0;
        if (lvl == 3'd7) return 1'b1;
        span = 1 << (int'(lvl) - 1);
        if (span > num_pages) span = num_pages;
        return pg >= (num_pages - span);
    endfunction
endpackage

// File: rtl/spi_pp_link.sv
// SPI mode-0 serial front end in the system clock domain.
// Assumes csn/sck/mosi are already synchronous to clk and that SCK holds
// each level for at least four clk cycles. Delivers whole received bytes,
// flags chip-select release with byte alignment, and shifts reply bytes out.
module spi_pp_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn,
    input  logic       sck,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       cs_end,
    output logic       cs_on_boundary,
    output logic       miso
);
    logic       sck_q;
    logic       csn_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sck_rise;
    logic       sck_fall;

    assign sck_rise       = sck & ~sck_q & ~csn;
    assign sck_fall       = ~sck & sck_q & ~csn;
    assign cs_end         = csn & ~csn_q;
    assign cs_on_boundary = (bit_cnt == 3'd0);

    // Edge history of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck;
            csn_q <= csn;
        end
    end

    // Receive shifter, bit counter and byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (csn) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb  <= 1'b1;
                    byte_data <= {rx_sh, mosi};
                end
            end
        end
    end

    // Transmit shifter: loaded on request, advanced on SCK falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (csn) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (sck_fall) begin
            miso  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> (bit_cnt == 3'd0));
    // R1
    stb_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (bit_cnt == 3'd0));
endmodule

// File: rtl/spi_pp_pagebuf.sv
// 256-entry staging buffer for one page of program data.
// Each entry carries a valid flag, so offsets that were never written are
// skipped at commit. A later write to an offset replaces the earlier one.
module spi_pp_pagebuf #(
    parameter int OFS_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [OFS_BITS-1:0] wr_ofs,
    input  logic [7:0]          wr_data,
    input  logic [OFS_BITS-1:0] rd_ofs,
    output logic [7:0]          rd_data,
    output logic                rd_valid
);
    localparam int ENTRIES = 1 << OFS_BITS;

    logic [7:0]         data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Data store, no reset needed since valid flags guard it.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_ofs] <= wr_data;
    end

    // Valid flags: cleared per command, set per written offset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid_q <= '0;
        else if (wr_en) valid_q[wr_ofs] <= 1'b1;
    end

    assign rd_data  = data_q[rd_ofs];
    assign rd_valid = valid_q[rd_ofs];

    // R5
    wr_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid_q[$past(wr_ofs)]);
endmodule

// File: rtl/spi_pp_array.sv
// Byte-wide storage array that only clears bits on a write.
// Resets to the erased value 0xFF; asynchronous read port.
module spi_pp_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Erase on reset, AND-program on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4
    no_set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == 8'h00));
endmodule

// File: rtl/spi_pp_ctrl.sv
// Command sequencer: opcode decode, write-enable latch, address capture,
// staging-buffer writes, commit decision at chip-select release, and the
// self-timed program period that copies valid buffer bytes into the array.
// Assumes TPP_CYCLES >= 256 so that every page offset gets one write slot.
module spi_pp_ctrl
    import spi_pp_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int TPP_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              cs_end,
    input  logic              cs_on_boundary,
    input  logic [2:0]        bp,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic              buf_clr,
    output logic              buf_wr,
    output logic [OFS_W-1:0]  buf_ofs,
    output logic [7:0]        buf_data,
    output logic [OFS_W-1:0]  buf_rd_ofs,
    input  logic [7:0]        buf_rd_data,
    input  logic              buf_rd_valid,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [7:0]        arr_rdata,
    output logic              wip,
    output logic              wel
);
    localparam int PAGE_W    = ADDR_W - OFS_W;
    localparam int NUM_PAGES = 1 << PAGE_W;
    localparam int CNT_W     = $clog2(TPP_CYCLES + 1);
    localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TPP_CYCLES - 1);
    localparam logic [CNT_W-1:0] T_PAGE = CNT_W'(PAGE_BYTES);

    cmd_state_t         state;
    logic [1:0]         addr_cnt;
    logic               kind_prog;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  next_addr;
    logic [OFS_W-1:0]   ptr;
    logic               got_data;
    logic [ADDR_W-1:0]  rd_ptr;
    logic [PAGE_W-1:0]  prog_page;
    logic [CNT_W-1:0]   tcnt;
    logic [7:0]         status;
    logic               locked;
    logic               start;
    logic               addr_last;

    assign status    = {3'b000, bp, wel, wip};
    assign next_addr = ADDR_W'({addr_q, byte_data});
    assign addr_last = (state == ST_ADDR) && (addr_cnt == 2'd2);
    assign locked    = page_locked(bp, int'(addr_q[ADDR_W-1:OFS_W]), NUM_PAGES);
    assign start     = cs_end && (state == ST_PROG_DATA) && cs_on_boundary
                       && got_data && !locked;

    // Reply selection for the serial transmitter.
    always_comb begin
        tx_load   = 1'b0;
        tx_byte   = status;
        arr_raddr = addr_last ? next_addr : rd_ptr;
        if (byte_stb) begin
            case (state)
                ST_OPCODE:    tx_load = (byte_data == OP_RDSR);
                ST_STATUS:    tx_load = 1'b1;
                ST_ADDR: if (addr_cnt == 2'd2 && !kind_prog) begin
                    tx_load = 1'b1;
                    tx_byte = arr_rdata;
                end
                ST_READ: begin
                    tx_load = 1'b1;
                    tx_byte = arr_rdata;
                end
                default: tx_load = 1'b0;
            endcase
        end
    end

    // Staging-buffer write port and commit read port.
    always_comb begin
        buf_clr    = byte_stb && addr_last && kind_prog;
        buf_wr     = byte_stb && (state == ST_PROG_DATA);
        buf_ofs    = ptr;
        buf_data   = byte_data;
        buf_rd_ofs = tcnt[OFS_W-1:0];
        arr_we     = wip && (tcnt < T_PAGE) && buf_rd_valid;
        arr_waddr  = {prog_page, tcnt[OFS_W-1:0]};
        arr_wdata  = buf_rd_data;
    end

    // Command state machine, advanced once per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPCODE;
            addr_cnt  <= '0;
            kind_prog <= 1'b0;
            addr_q    <= '0;
            ptr       <= '0;
            got_data  <= 1'b0;
            rd_ptr    <= '0;
        end else if (cs_end) begin
            state    <= ST_OPCODE;
            addr_cnt <= '0;
            got_data <= 1'b0;
        end else if (byte_stb) begin
            case (state)
                ST_OPCODE: begin
                    if (wip) begin
                        state <= (byte_data == OP_RDSR) ? ST_STATUS : ST_DISCARD;
                    end else begin
                        case (byte_data)
                            OP_RDSR: state <= ST_STATUS;
                            OP_READ: begin
                                state     <= ST_ADDR;
                                kind_prog <= 1'b0;
                            end
                            OP_PROG: begin
                                state     <= wel ? ST_ADDR : ST_DISCARD;
                                kind_prog <= 1'b1;
                            end
                            default: state <= ST_DISCARD;
                        endcase
                    end
                end
                ST_ADDR: begin
                    addr_q   <= next_addr;
                    addr_cnt <= addr_cnt + 2'd1;
                    if (addr_cnt == 2'd2) begin
                        state  <= kind_prog ? ST_PROG_DATA : ST_READ;
                        ptr    <= byte_data;
                        rd_ptr <= next_addr + ADDR_W'(1);
                    end
                end
                ST_PROG_DATA: begin
                    ptr      <= ptr + OFS_W'(1);
                    got_data <= 1'b1;
                end
                ST_READ: rd_ptr <= rd_ptr + ADDR_W'(1);
                default: state <= state;
            endcase
        end
    end

    // Write-enable latch: set by the enable opcode, cleared at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) wel <= 1'b0;
        else if (start) wel <= 1'b0;
        else if (byte_stb && state == ST_OPCODE && !wip && byte_data == OP_WREN) wel <= 1'b1;
    end

    // Self-timed program period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip       <= 1'b0;
            tcnt      <= '0;
            prog_page <= '0;
        end else if (start) begin
            wip       <= 1'b1;
            tcnt      <= '0;
            prog_page <= addr_q[ADDR_W-1:OFS_W];
        end else if (wip) begin
            tcnt <= tcnt + CNT_W'(1);
            if (tcnt == T_LAST) wip <= 1'b0;
        end
    end

    // R9
    start_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wip && !wel));
    // R11
    busy_no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !wel);
    // R3
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wel);
    // R9
    write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (wip && tcnt <= T_LAST));
endmodule

// File: rtl/spi_pp_flash.sv
// Top level of the serial flash page program engine: wires the SPI front
// end, command sequencer, staging buffer and storage array together.
// Assumes ADDR_W > 8 (at least one full page) and TPP_CYCLES >= 256.
module spi_pp_flash #(
    parameter int ADDR_W     = 10,
    parameter int TPP_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [2:0] prot_bits,
    output logic       busy
);
    import spi_pp_pkg::*;

    logic              byte_stb;
    logic [7:0]        byte_data;
    logic              cs_end;
    logic              cs_on_boundary;
    logic              tx_load;
    logic [7:0]        tx_byte;
    logic              buf_clr;
    logic              buf_wr;
    logic [OFS_W-1:0]  buf_ofs;
    logic [7:0]        buf_data;
    logic [OFS_W-1:0]  buf_rd_ofs;
    logic [7:0]        buf_rd_data;
    logic              buf_rd_valid;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [ADDR_W-1:0] arr_raddr;
    logic [7:0]        arr_rdata;
    logic              wip;
    logic              wel;

    assign busy = wip;

    spi_pp_link u_link (
        .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
        .tx_load(tx_load), .tx_byte(tx_byte), .byte_stb(byte_stb),
        .byte_data(byte_data), .cs_end(cs_end), .cs_on_boundary(cs_on_boundary),
        .miso(spi_miso)
    );

    spi_pp_ctrl #(.ADDR_W(ADDR_W), .TPP_CYCLES(TPP_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
        .cs_end(cs_end), .cs_on_boundary(cs_on_boundary), .bp(prot_bits),
        .tx_load(tx_load), .tx_byte(tx_byte), .buf_clr(buf_clr), .buf_wr(buf_wr),
        .buf_ofs(buf_ofs), .buf_data(buf_data), .buf_rd_ofs(buf_rd_ofs),
        .buf_rd_data(buf_rd_data), .buf_rd_valid(buf_rd_valid), .arr_we(arr_we),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_raddr(arr_raddr),
        .arr_rdata(arr_rdata), .wip(wip), .wel(wel)
    );

    spi_pp_pagebuf #(.OFS_BITS(OFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_ofs(buf_ofs),
        .wr_data(buf_data), .rd_ofs(buf_rd_ofs), .rd_data(buf_rd_data),
        .rd_valid(buf_rd_valid)
    );

    spi_pp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(arr_raddr), .rdata(arr_rdata)
    );
endmodule

// File: tb/tb_spi_pp_flash.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_spi_pp_flash;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int TPP        = 2000;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic [2:0] prot_bits = 3'd0;
    logic       spi_miso;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [DEPTH];
    logic [7:0] pdata [300];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pp_flash #(.ADDR_W(AW), .TPP_CYCLES(TPP)) dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .prot_bits(prot_bits), .busy(busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b >= 8 - nb; b--) begin
            spi_mosi = tx[b];
            tick(HALF);
            rx[b] = spi_miso;
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_high();
        tick(HALF);
        spi_csn = 1'b1;
        tick(HALF);
    endtask

    task automatic wren();
        logic [7:0] r;
        cs_low(); xfer(8'h06, r); cs_high();
    endtask

    task automatic status_is(input logic [7:0] exp, input string req);
        logic [7:0] r;
        cs_low(); xfer(8'h05, r); xfer(8'h00, r); cs_high();
        check(r == exp, req, r, exp);
    endtask

    // Apply wraparound, last-writer-wins and AND to the expected array.
    task automatic model_prog(input logic [23:0] a, input int n);
        logic [7:0] tb_d [256];
        bit tb_v [256];
        int base;
        for (int i = 0; i < 256; i++) tb_v[i] = 1'b0;
        for (int j = 0; j < n; j++) begin
            int o;
            o = (int'(a[7:0]) + j) % 256;
            tb_d[o] = pdata[j];
            tb_v[o] = 1'b1;
        end
        base = int'(a[AW-1:8]) * 256;
        for (int i = 0; i < 256; i++)
            if (tb_v[i]) exp_mem[base + i] = exp_mem[base + i] & tb_d[i];
    endtask

    task automatic do_prog(input logic [23:0] a, input int n, input bit run,
                           input bit measure, input string req);
        logic [7:0] r;
        int cnt;
        cs_low();
        xfer(8'h02, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int j = 0; j < n; j++) xfer(pdata[j], r);
        tick(HALF);
        spi_csn = 1'b1;
        if (run) model_prog(a, n);
        if (measure) begin
            cnt = 0;
            tick(1);
            while (busy && cnt < TPP + 10) begin
                cnt++;
                tick(1);
            end
            if (run) check(cnt == TPP, "R9", cnt, TPP);
            else     check(cnt == 0, req, cnt, 0);
            tick(HALF);
        end else begin
            tick(2);
        end
    endtask

    // R12: sequential read compared with the expected array.
    task automatic read_check(input int a, input int n, input string req);
        logic [7:0] r;
        logic [23:0] av;
        av = 24'(a);
        cs_low();
        xfer(8'h03, r); xfer(av[23:16], r); xfer(av[15:8], r); xfer(av[7:0], r);
        for (int j = 0; j < n; j++) begin
            int idx;
            idx = (a + j) % DEPTH;
            xfer(8'h00, r);
            check(r == exp_mem[idx], req, r, exp_mem[idx]);
        end
        cs_high();
    endtask

    task automatic t_reset();
        status_is(8'h00, "R14");
        read_check(DEPTH - 2, 4, "R14");
        read_check(16, 2, "R12");
    endtask

    task automatic t_no_wel();
        pdata[0] = 8'h00;
        do_prog(24'h000010, 1, 1'b0, 1'b1, "R3");
        read_check(16, 1, "R3");
        status_is(8'h00, "R3");
    endtask

    task automatic t_wren();
        wren();
        status_is(8'h02, "R2");
    endtask

    task automatic t_short();
        pdata[0] = 8'h5A; pdata[1] = 8'hC3; pdata[2] = 8'h0F;
        do_prog(24'h000010, 3, 1'b1, 1'b1, "R9");
        status_is(8'h00, "R9");
        read_check(14, 8, "R5");
    endtask

    task automatic t_and();
        wren();
        pdata[0] = 8'hF0;
        do_prog(24'h000010, 1, 1'b1, 1'b1, "R4");
        read_check(16, 1, "R4");
        check(exp_mem[16] == 8'h50, "R4", exp_mem[16], 8'h50);
    endtask

    task automatic t_wrap();
        wren();
        pdata[0] = 8'h11; pdata[1] = 8'h22; pdata[2] = 8'h33; pdata[3] = 8'h44;
        do_prog(24'hF5FDFE, 4, 1'b1, 1'b1, "R6");
        read_check(12'h1FC, 4, "R6");
        read_check(12'h100, 3, "R6");
    endtask

    task automatic t_overrun();
        wren();
        for (int j = 0; j < 260; j++) pdata[j] = 8'(j) ^ ((j >= 256) ? 8'hA5 : 8'h00);
        do_prog(24'h000200, 260, 1'b1, 1'b1, "R7");
        read_check(12'h200, 256, "R7");
    endtask

    task automatic t_misalign();
        logic [7:0] r;
        int cnt;
        wren();
        cs_low();
        xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r);
        xfer(8'h00, r);
        xfer_bits(8'hFF, 3, r);
        tick(HALF);
        spi_csn = 1'b1;
        cnt = 0;
        tick(1);
        while (busy && cnt < TPP + 10) begin cnt++; tick(1); end
        check(cnt == 0, "R8", cnt, 0);
        tick(HALF);
        do_prog(24'h000040, 0, 1'b0, 1'b1, "R8");
        read_check(12'h040, 2, "R8");
        status_is(8'h02, "R8");
    endtask

    task automatic t_protect();
        prot_bits = 3'd1;
        wren();
        status_is(8'h06, "R10");
        pdata[0] = 8'h00;
        do_prog(24'h000300, 1, 1'b0, 1'b1, "R10");
        read_check(12'h300, 1, "R10");
        wren();
        pdata[0] = 8'h77;
        do_prog(24'h000150, 1, 1'b1, 1'b1, "R10");
        read_check(12'h150, 1, "R10");
        prot_bits = 3'd7;
        wren();
        pdata[0] = 8'h00;
        do_prog(24'h000000, 1, 1'b0, 1'b1, "R10");
        read_check(0, 1, "R10");
        prot_bits = 3'd0;
    endtask

    task automatic t_busy();
        logic [7:0] r;
        logic [7:0] first;
        int k;
        wren();
        pdata[0] = 8'h3C;
        do_prog(24'h000080, 1, 1'b1, 1'b0, "R11");
        status_is(8'h01, "R9");
        wren();
        status_is(8'h01, "R11");
        cs_low();
        xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h80, r);
        xfer(8'h00, r);
        check(r == 8'h00, "R11", r, 8'h00);
        cs_high();
        cs_low();
        xfer(8'h05, r);
        xfer(8'h00, first);
        r = first;
        k = 0;
        while (r != 8'h00 && k < 200) begin
            xfer(8'h00, r);
            k++;
        end
        cs_high();
        check(first == 8'h01, "R13", first, 8'h01);
        check(r == 8'h00, "R13", r, 8'h00);
        read_check(12'h080, 1, "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check(busy == 1'b0 && spi_miso == 1'b0, "R14", {busy, spi_miso}, 0);
        t_reset();
        t_no_wel();
        t_wren();
        t_short();
        t_and();
        t_wrap();
        t_overrun();
        t_misalign();
        t_protect();
        t_busy();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule